// File: doc/BRIEF.md
# Lock-Aware Shared-Slave Arbiter

This block lets several bus masters share one memory-mapped slave port. Each master drives a request, a read or write strobe, an address, write data and a lock input. The arbiter grants the port to one master at a time and forwards that master's command to the slave. It gives each master a grant flag and a wait-request flag. When a read is accepted, the block records which master issued it. Each later read response from the slave is then steered to that master, in the order the reads were accepted.

Masters without lock are served in round-robin order. A master that is granted and holds its lock input high keeps the slave across a run of transactions. It keeps the slave even through idle cycles, and releases it only when a transfer is accepted with lock low, or when it is idle with lock low. Lock does not help a master win the port: lock inputs of masters that are not granted are ignored. There is no priority setting, so every master can use lock on the same terms. A master whose transfer is not accepted sees wait-request high and must hold its command steady.

Top module: `lockarb_top`

## Requirements
- R1: While reset is high, on the following cycle no grant is high and every wait-request is high. The first arbitration after reset searches from master 0 upward.
- R2: At most one grant output is high in any cycle.
- R3: When the arbiter re-arbitrates, the grant moves to the first master with its request high, searching upward from the master granted last and wrapping past the highest index. If no master requests, no grant is given.
- R4: Re-arbitration happens only in three cases: nobody holds the grant, or the owner's lock is low and its transfer is accepted, or the owner's lock is low and its request is low. In every other cycle the grant is unchanged.
- R5: While the granted master holds lock high, it keeps the grant on every following cycle. This holds whether or not it is requesting and whatever other masters do.
- R6: The lock input of a master that is not granted has no effect on which master is chosen.
- R7: The slave read strobe is high only when the owner requests with its read strobe high and fewer than RSP_DEPTH reads are outstanding. The slave write strobe is high when the owner requests with its write strobe high. The slave address and write data are those of the owner.
- R8: A master's wait-request is low only in a cycle where that master is granted, its command reaches the slave, and the slave's wait input is low. That cycle is the acceptance of the transfer.
- R9: Each slave response with read-valid high raises the read-valid of exactly one master: the master whose accepted read is the oldest one still unanswered. Read data is passed to all masters unchanged.
- R10: No more than RSP_DEPTH reads are ever outstanding. A read from the owner at that limit is held with its wait-request high until a response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_req | input | N_MST | Request, one bit per master |
| mst_lock | input | N_MST | Lock, one bit per master |
| mst_rd | input | N_MST | Read strobe per master |
| mst_wr | input | N_MST | Write strobe per master |
| mst_addr | input | N_MST x ARB_AW | Address per master |
| mst_wdata | input | N_MST x ARB_DW | Write data per master |
| mst_gnt | output | N_MST | Grant per master |
| mst_wait | output | N_MST | Wait-request per master |
| mst_rvalid | output | N_MST | Read-valid per master |
| mst_rdata | output | ARB_DW | Read data, shared by all masters |
| slv_rd | output | 1 | Read strobe to the slave |
| slv_wr | output | 1 | Write strobe to the slave |
| slv_addr | output | ARB_AW | Address to the slave |
| slv_wdata | output | ARB_DW | Write data to the slave |
| slv_wait | input | 1 | Wait-request from the slave |
| slv_rvalid | input | 1 | Read-valid from the slave |
| slv_rdata | input | ARB_DW | Read data from the slave |

## Verification
The bench builds the arbiter with three masters, so the round-robin search wraps after three steps and the order in which masters are skipped is visible. It sets the response queue depth to two, so that the read limit is reached often. Random slave stalls, slow responses and long locked runs drive the block into the held-read case of R10. They also produce locked owners that sit idle and non-owners that hold lock while they wait.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int ARB_AW = 16;
    localparam int ARB_DW = 32;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ARB_AW-1:0] addr;
        logic [ARB_DW-1:0] wdata;
    } arb_cmd_t;

    // cyclic successor of an index among n masters
    function automatic int arb_wrap(input int base, input int step, input int n);
        return (base + step) % n;
    endfunction

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick import arb_pkg::*; #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          any,
    output logic [IW-1:0] pick
);
    always_comb begin
        any  = 1'b0;
        pick = last;
        for (int k = 1; k <= N; k++) begin
            if (!any && req[arb_wrap(int'(last), k, N)]) begin
                any  = 1'b1;
                pick = IW'(arb_wrap(int'(last), k, N));
            end
        end
    end
endmodule

// File: rtl/arb_owner.sv
module arb_owner #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  lock,
    input  logic          acc,
    output logic          own_vld,
    output logic [IW-1:0] own_idx
);
    logic          any;
    logic [IW-1:0] pick;
    logic          rearb;

    // own_idx doubles as the round-robin pointer when nobody owns the port
    arb_rr_pick #(.N(N), .IW(IW)) u_pick (
        .req (req),
        .last(own_idx),
        .any (any),
        .pick(pick)
    );

    always_comb begin
        rearb = !own_vld || (!lock[own_idx] && (acc || !req[own_idx]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_vld <= 1'b0;
            own_idx <= IW'(N - 1);
        end else if (rearb) begin
            own_vld <= any;
            if (any) own_idx <= pick;
        end
    end
endmodule

// File: rtl/arb_rsp_fifo.sv
module arb_rsp_fifo #(
    parameter int DEPTH = 4,
    parameter int IW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [IW-1:0] push_id,
    input  logic          pop,
    output logic [IW-1:0] head_id,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [IW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign head_id = mem[rp];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                mem[wp] <= push_id;
                wp      <= bump(wp);
            end
            if (pop) rp <= bump(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/lockarb_top.sv
module lockarb_top import arb_pkg::*; #(
    parameter int N_MST     = 3,
    parameter int RSP_DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_MST-1:0]             mst_req,
    input  logic [N_MST-1:0]             mst_lock,
    input  logic [N_MST-1:0]             mst_rd,
    input  logic [N_MST-1:0]             mst_wr,
    input  logic [N_MST-1:0][ARB_AW-1:0] mst_addr,
    input  logic [N_MST-1:0][ARB_DW-1:0] mst_wdata,
    output logic [N_MST-1:0]             mst_gnt,
    output logic [N_MST-1:0]             mst_wait,
    output logic [N_MST-1:0]             mst_rvalid,
    output logic [ARB_DW-1:0]            mst_rdata,
    output logic                         slv_rd,
    output logic                         slv_wr,
    output logic [ARB_AW-1:0]            slv_addr,
    output logic [ARB_DW-1:0]            slv_wdata,
    input  logic                         slv_wait,
    input  logic                         slv_rvalid,
    input  logic [ARB_DW-1:0]            slv_rdata
);
    localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1;

    logic          own_vld;
    logic [IW-1:0] own_idx;
    logic          active, acc;
    logic          q_full, q_empty;
    logic [IW-1:0] q_head;
    arb_cmd_t      cur;

    arb_owner #(.N(N_MST), .IW(IW)) u_owner (
        .clk    (clk),
        .rst    (rst),
        .req    (mst_req),
        .lock   (mst_lock),
        .acc    (acc),
        .own_vld(own_vld),
        .own_idx(own_idx)
    );

    always_comb begin
        cur.rd    = mst_rd[own_idx];
        cur.wr    = mst_wr[own_idx];
        cur.addr  = mst_addr[own_idx];
        cur.wdata = mst_wdata[own_idx];
    end

    assign active    = own_vld && mst_req[own_idx];
    assign slv_rd    = active && cur.rd && !q_full;
    assign slv_wr    = active && cur.wr;
    assign slv_addr  = cur.addr;
    assign slv_wdata = cur.wdata;
    assign acc       = (slv_rd || slv_wr) && !slv_wait;

    arb_rsp_fifo #(.DEPTH(RSP_DEPTH), .IW(IW)) u_rsp (
        .clk    (clk),
        .rst    (rst),
        .push   (slv_rd && !slv_wait),
        .push_id(own_idx),
        .pop    (slv_rvalid && !q_empty),
        .head_id(q_head),
        .full   (q_full),
        .empty  (q_empty)
    );

    assign mst_rdata = slv_rdata;

    for (genvar g = 0; g < N_MST; g++) begin : g_port
        assign mst_gnt[g]    = own_vld && (own_idx == IW'(g));
        assign mst_wait[g]   = !(mst_gnt[g] && acc);
        assign mst_rvalid[g] = slv_rvalid && !q_empty && (q_head == IW'(g));
    end
endmodule

// File: rtl/lockarb_chk.sv
module lockarb_chk #(
    parameter int N_MST     = 3,
    parameter int RSP_DEPTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [N_MST-1:0] mst_req,
    input logic [N_MST-1:0] mst_lock,
    input logic [N_MST-1:0] mst_gnt,
    input logic [N_MST-1:0] mst_wait,
    input logic [N_MST-1:0] mst_rvalid,
    input logic             slv_rd,
    input logic             slv_wr,
    input logic             slv_wait,
    input logic             slv_rvalid
);
    int outstanding;

    always_ff @(posedge clk) begin
        if (rst) outstanding <= 0;
        else outstanding <= outstanding + int'(slv_rd && !slv_wait) - int'(|mst_rvalid);
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (mst_gnt == '0 && &mst_wait));

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mst_gnt));

    assert_hold_grant_R4: assert property (@(posedge clk) disable iff (rst)
        (|(mst_gnt & mst_req) && !((slv_rd || slv_wr) && !slv_wait)) |=> $stable(mst_gnt));

    assert_lock_keep_R5: assert property (@(posedge clk) disable iff (rst)
        |(mst_gnt & mst_lock) |=> (mst_gnt == $past(mst_gnt)));

    assert_cmd_owner_R7: assert property (@(posedge clk) disable iff (rst)
        (slv_rd || slv_wr) |-> |(mst_gnt & mst_req));

    assert_wait_owner_R8: assert property (@(posedge clk) disable iff (rst)
        &(mst_wait | mst_gnt));

    assert_rsp_route_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mst_rvalid) && (!(|mst_rvalid) || slv_rvalid));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        outstanding <= RSP_DEPTH);
endmodule

bind lockarb_top lockarb_chk #(.N_MST(N_MST), .RSP_DEPTH(RSP_DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mst_req   (mst_req),
    .mst_lock  (mst_lock),
    .mst_gnt   (mst_gnt),
    .mst_wait  (mst_wait),
    .mst_rvalid(mst_rvalid),
    .slv_rd    (slv_rd),
    .slv_wr    (slv_wr),
    .slv_wait  (slv_wait),
    .slv_rvalid(slv_rvalid)
);

// File: tb/sim_lockarb_top.sv
`timescale 1ns/1ps
module sim_lockarb_top;
    import arb_pkg::*;

    localparam int N = 3;
    localparam int D = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;
    logic rst = 1'b1;

    logic [N-1:0]             req = '0, lck = '0, rd = '0, wr = '0;
    logic [N-1:0][ARB_AW-1:0] addr = '0;
    logic [N-1:0][ARB_DW-1:0] wdata = '0;
    logic [N-1:0]             gnt, wt, rv;
    logic [ARB_DW-1:0]        mrdata, sdata = '0;
    logic                     srd, swr, swait = 1'b0, srv = 1'b0;
    logic [ARB_AW-1:0]        saddr;
    logic [ARB_DW-1:0]        swdata;

    lockarb_top #(.N_MST(N), .RSP_DEPTH(D)) u0 (
        .clk(clk), .rst(rst), .mst_req(req), .mst_lock(lck), .mst_rd(rd), .mst_wr(wr),
        .mst_addr(addr), .mst_wdata(wdata), .mst_gnt(gnt), .mst_wait(wt), .mst_rvalid(rv),
        .mst_rdata(mrdata), .slv_rd(srd), .slv_wr(swr), .slv_addr(saddr), .slv_wdata(swdata),
        .slv_wait(swait), .slv_rvalid(srv), .slv_rdata(sdata)
    );

    int n_cmp = 0, n_bad = 0;
    bit m_vld = 1'b0;
    int m_idx = N - 1;
    int q[$];
    int busy[N], lock_left[N], gap[N];

    task automatic chk(input bit ok, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got %0h exp %0h at %0t", what, got, exp, $time);
        end
    endtask

    task automatic step(input int p_wait, input int p_rsp, input int p_lock);
        bit e_rd, e_wr, acc, rearb, n_vld, found;
        int n_idx;
        logic [N-1:0] e_gnt, e_wait, e_rv;
        // drive at the falling edge
        swait = ($urandom % 100) < p_wait;
        srv   = (q.size() > 0) && (($urandom % 100) < p_rsp);
        sdata = $urandom;
        for (int i = 0; i < N; i++) begin
            if (busy[i] == 0) begin
                if (gap[i] > 0) gap[i]--;
                else begin
                    busy[i] = 1;
                    if (lock_left[i] == 0 && ($urandom % 100) < p_lock) lock_left[i] = 2 + $urandom % 3;
                    rd[i]    = $urandom % 2;
                    wr[i]    = !rd[i];
                    addr[i]  = ARB_AW'($urandom);
                    wdata[i] = $urandom;
                end
            end
            req[i] = (busy[i] != 0);
            lck[i] = (lock_left[i] > 1);
        end
        #1;
        e_rd  = m_vld && req[m_idx] && rd[m_idx] && (q.size() < D);
        e_wr  = m_vld && req[m_idx] && wr[m_idx];
        acc   = (e_rd || e_wr) && !swait;
        e_gnt = m_vld ? N'(1 << m_idx) : '0;
        e_wait = '1;
        if (acc) e_wait[m_idx] = 1'b0;
        e_rv = srv ? N'(1 << q[0]) : '0;
        chk(gnt == e_gnt, "R2 R3 R4 R5 R6 grant", 64'(gnt), 64'(e_gnt));
        chk(wt == e_wait, "R8 wait", 64'(wt), 64'(e_wait));
        chk(srd == e_rd, "R7 R10 slave read", 64'(srd), 64'(e_rd));
        chk(swr == e_wr, "R7 slave write", 64'(swr), 64'(e_wr));
        if (e_rd || e_wr) chk(saddr == addr[m_idx], "R7 address", 64'(saddr), 64'(addr[m_idx]));
        if (e_wr) chk(swdata == wdata[m_idx], "R7 write data", 64'(swdata), 64'(wdata[m_idx]));
        chk(rv == e_rv, "R9 read valid", 64'(rv), 64'(e_rv));
        if (srv) chk(mrdata == sdata, "R9 read data", 64'(mrdata), 64'(sdata));
        // next state from the requirements
        rearb = !m_vld || (!lck[m_idx] && (acc || !req[m_idx]));
        n_vld = m_vld;
        n_idx = m_idx;
        if (rearb) begin
            found = 1'b0;
            for (int k = 1; k <= N; k++) begin
                if (!found && req[(m_idx + k) % N]) begin
                    found = 1'b1;
                    n_idx = (m_idx + k) % N;
                end
            end
            n_vld = found;
        end
        if (srv) void'(q.pop_front());
        if (e_rd && !swait) q.push_back(m_idx);
        if (acc) begin
            busy[m_idx] = 0;
            gap[m_idx]  = $urandom % 3;
            if (lock_left[m_idx] > 0) lock_left[m_idx]--;
        end
        @(posedge clk);
        m_vld = n_vld;
        m_idx = n_idx;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            busy[i] = 0; lock_left[i] = 0; gap[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        req = '1; lck = '1; rd = '1;
        #1;
        chk(gnt == '0, "R1 grant in reset", 64'(gnt), 64'(0));
        chk(wt == '1, "R1 wait in reset", 64'(wt), 64'((1 << N) - 1));
        chk(srd == 1'b0 && swr == 1'b0, "R1 slave idle in reset", 64'({srd, swr}), 64'(0));
        @(negedge clk);
        rst = 1'b0;
        req = '0; lck = '0; rd = '0;
        m_vld = 1'b0;
        m_idx = N - 1;
        // all start together: first grant must go to master 0 (R1, R3)
        repeat (1500) step(20, 60, 0);
        repeat (1500) step(30, 50, 60);
        repeat (1500) step(50, 15, 40);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule